// File: doc/BRIEF.md
# Serial Clock and Parameter-Memory Command Engine

This block is the device end of a three-wire serial link that carries a clock calendar and a small parameter memory. The host pulls an active-low select low, toggles a serial clock and moves data one bit per clock period. The engine assembles bytes, decodes a one-byte command and runs a transaction of one, two or three bytes. Reads are answered by shifting a byte back to the host. The data line is modelled as an input, an output and an output enable; the enable marks when the device owns the wire.

Storage is one 256-byte memory, split into eight sectors of 32 bytes. Its first 20 bytes can also be reached with short direct commands. The engine also holds a 32-bit seconds count that starts at zero, which stands for the start of 1904, and goes up by one on each pulse of a one-second tick input. A write-protect flag blocks every write command except those aimed at the protect register itself.

The serial inputs are oversampled by the system clock through synchronisers. The serial clock idles high between transactions.

Top module: `rtc_pram_engine`

## Requirements
- R1: While `rtc_en_n` is high, serial clock edges and data bits have no effect: no bit is counted, no byte is processed, and the output enable stays low.
- R2: When the host sends, the engine takes `rtc_sdi` on each rising serial clock edge, most significant bit first, and handles a byte after its eighth bit.
- R3: For a read, the engine raises `rtc_sdo_oe`. It puts bit 7 first on `rtc_sdo`, then each next bit, one bit at each falling serial clock edge. It drops `rtc_sdo_oe` on the rising edge that follows the eighth bit.
- R4: Command `r0000nn01` reads byte nn of the seconds count, with byte 0 the least significant. Bit 7 of a command, r, is 1 for a read and 0 for a write. The count goes up by one for each cycle in which `sec_tick` is high.
- R5: Command `r1aaaa01` reaches memory byte aaaa (0x00 to 0x0F). Command `r010aa01` reaches byte 0x10+aa. A write sends one data byte after the command. A read returns the byte.
- R6: Command `r0111sss` selects sector sss. The next byte gives a 5-bit address in its bits 6:2. The memory index is sss*32+address. A read then returns that byte. A write takes one more byte as the data.
- R7: Command 0x35 writes the protect flag from bit 7 of its data byte. While the flag is set, every other write command is dropped, and the bytes after it are decoded as commands. Reads still work.
- R8: A command byte that matches no pattern is dropped, and the next byte is taken as a command. This includes 0xB1 and 0xB5, the read forms of the test and protect registers.
- R9: A write to a seconds byte, or to the test register (0x31), takes its data byte and changes nothing.
- R10: After reset the engine expects a command byte, any partly received byte is discarded, the protect flag is clear, the seconds count is zero and `rtc_sdo_oe` is low.
- R11: The direct form and sector 0 of the sector form reach the same storage for bytes 0x00 to 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rtc_en_n | input | 1 | Active-low transaction select |
| rtc_sclk | input | 1 | Serial clock from the host |
| rtc_sdi | input | 1 | Serial data from the host |
| rtc_sdo | output | 1 | Serial data to the host |
| rtc_sdo_oe | output | 1 | High while the device drives the data line |

## Verification
The command decoder is tried with every command family: direct low and high bytes, sector addresses up to the last byte of the last sector, and every seconds byte after a known number of ticks. Wrong bit order, a wrong byte lane or a wrong address field all show up as a mismatched read-back. Aliasing between the direct and sector forms confirms that both share one index map. Data bytes that look like valid read commands are sent after test and seconds writes, and after dropped protected writes. If the engine loses track of the transaction framing, those bytes start a stray read, which the output enable reveals. A mid-byte reset, and clock toggles while the select is high, show whether the engine stays in step with byte boundaries.

// File: rtl/rtc_pram_pkg.sv
package rtc_pram_pkg;

  localparam int SECT_W  = 3;
  localparam int XADDR_W = 5;
  localparam int IDX_W   = SECT_W + XADDR_W;
  localparam int MEM_DEPTH = 1 << IDX_W;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_SECS,
    CK_TEST,
    CK_WPROT,
    CK_DIRECT,
    CK_EXT
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } cmd_dec_t;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_DATA,
    ST_XADDR,
    ST_XDATA,
    ST_RDWAIT
  } eng_state_e;

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[g] <= RST_VAL;
        end else if (g == 0) begin
          chain[g] <= d;
        end else begin
          chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rtc_bit_shifter.sv
module rtc_bit_shifter #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [2:0] raw_s;
  logic       en_s, sclk_s, sdi_s, sclk_d;
  logic       rise, fall;
  logic [CNT_W-1:0]  rx_cnt, tx_left;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic              tx_mode;

  rtc_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({en_n, sclk, sdi}),
    .q  (raw_s)
  );

  assign en_s   = raw_s[2];
  assign sclk_s = raw_s[1];
  assign sdi_s  = raw_s[0];
  assign rise   = !en_s && sclk_s && !sclk_d;
  assign fall   = !en_s && !sclk_s && sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b1;
      rx_cnt    <= '0;
      rx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      tx_sr     <= '0;
      tx_left   <= '0;
      tx_mode   <= 1'b0;
      sdo       <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      byte_done <= 1'b0;
      if (load) begin
        tx_sr   <= load_byte;
        tx_left <= CNT_W'(BYTE_W);
        tx_mode <= 1'b1;
      end else if (tx_mode) begin
        if (fall && tx_left != '0) begin
          sdo     <= tx_sr[BYTE_W-1];
          tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
          tx_left <= tx_left - 1'b1;
        end else if (rise && tx_left == '0) begin
          tx_mode <= 1'b0;
        end
      end else if (rise) begin
        rx_sr <= {rx_sr[BYTE_W-2:0], sdi_s};
        if (rx_cnt == CNT_W'(BYTE_W - 1)) begin
          rx_cnt    <= '0;
          rx_byte   <= {rx_sr[BYTE_W-2:0], sdi_s};
          byte_done <= 1'b1;
        end else begin
          rx_cnt <= rx_cnt + 1'b1;
        end
      end
    end
  end

  assign sdo_oe = tx_mode;

  AST_RX_FROZEN_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    en_s |=> $stable(rx_cnt)); // R1

  AST_BYTE_FROM_RISE: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> ($past(rise) && !$past(tx_mode))); // R2

  AST_TX_ENDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_mode) |-> ($past(tx_left) == '0)); // R3

endmodule

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_pram_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_dec_t   dec
);

  logic [6:0] v;
  logic [4:0] w;

  assign v = cmd_byte[6:0];
  assign w = v[6:2];

  always_comb begin
    dec      = '0;
    dec.kind = CK_NONE;
    dec.rd   = cmd_byte[7];
    if (v[6:3] == 4'b0111) begin
      dec.kind = CK_EXT;
      dec.idx  = IDX_W'(v[2:0]);
    end else if (v[1:0] == 2'b01) begin
      if (w[4:2] == 3'b000) begin
        dec.kind = CK_SECS;
        dec.idx  = IDX_W'(w[1:0]);
      end else if (w == 5'h0c && !cmd_byte[7]) begin
        dec.kind = CK_TEST;
      end else if (w == 5'h0d && !cmd_byte[7]) begin
        dec.kind = CK_WPROT;
      end else if (w[4:2] == 3'b010) begin
        dec.kind = CK_DIRECT;
        dec.idx  = IDX_W'(8'h10 + {6'd0, w[1:0]});
      end else if (w[4]) begin
        dec.kind = CK_DIRECT;
        dec.idx  = IDX_W'(w[3:0]);
      end
    end
  end

endmodule

// File: rtl/rtc_param_mem.sv
module rtc_param_mem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end

endmodule

// File: rtl/rtc_pram_engine.sv
module rtc_pram_engine
  import rtc_pram_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEC_W       = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic rtc_en_n,
  input  logic rtc_sclk,
  input  logic rtc_sdi,
  output logic rtc_sdo,
  output logic rtc_sdo_oe
);

  localparam int BYTE_W    = 8;
  localparam int SEC_BYTES = SEC_W / BYTE_W;
  localparam int SEL_W     = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1;

  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              ld;
  logic [BYTE_W-1:0] ld_data;
  cmd_dec_t          dec;

  eng_state_e        state, nstate;
  cmd_kind_e         pend_kind;
  logic              pend_rd;
  logic [IDX_W-1:0]  pend_idx;
  logic              wp;
  logic [SEC_W-1:0]  secs;

  logic              mem_we;
  logic [IDX_W-1:0]  mem_addr;
  logic [BYTE_W-1:0] mem_rdata;
  logic [IDX_W-1:0]  ext_idx;
  logic [SEL_W-1:0]  sec_sel;

  rtc_bit_shifter #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W     (BYTE_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .en_n     (rtc_en_n),
    .sclk     (rtc_sclk),
    .sdi      (rtc_sdi),
    .load     (ld),
    .load_byte(ld_data),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .sdo      (rtc_sdo),
    .sdo_oe   (rtc_sdo_oe)
  );

  rtc_cmd_decode u_dec (
    .cmd_byte(rx_byte),
    .dec     (dec)
  );

  rtc_param_mem #(
    .DEPTH (MEM_DEPTH),
    .DATA_W(BYTE_W)
  ) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(rx_byte),
    .rdata(mem_rdata)
  );

  assign ext_idx = {pend_idx[SECT_W-1:0], rx_byte[XADDR_W+1:2]};
  assign sec_sel = SEL_W'(dec.idx);

  always_comb begin
    nstate   = state;
    mem_we   = 1'b0;
    mem_addr = pend_idx;
    ld       = 1'b0;
    ld_data  = '0;
    unique case (state)
      ST_CMD: begin
        if (byte_done) begin
          unique case (dec.kind)
            CK_SECS: begin
              if (dec.rd) begin
                ld      = 1'b1;
                ld_data = secs[sec_sel*BYTE_W +: BYTE_W];
              end else if (!wp) begin
                nstate = ST_DATA;
              end
            end
            CK_TEST: if (!wp) nstate = ST_DATA;
            CK_WPROT: nstate = ST_DATA;
            CK_DIRECT: begin
              if (dec.rd) begin
                mem_addr = dec.idx;
                nstate   = ST_RDWAIT;
              end else if (!wp) begin
                nstate = ST_DATA;
              end
            end
            CK_EXT: if (dec.rd || !wp) nstate = ST_XADDR;
            default: nstate = ST_CMD;
          endcase
        end
      end
      ST_DATA: begin
        if (byte_done) begin
          mem_we = (pend_kind == CK_DIRECT);
          nstate = ST_CMD;
        end
      end
      ST_XADDR: begin
        if (byte_done) begin
          mem_addr = ext_idx;
          nstate   = pend_rd ? ST_RDWAIT : ST_XDATA;
        end
      end
      ST_XDATA: begin
        if (byte_done) begin
          mem_we = 1'b1;
          nstate = ST_CMD;
        end
      end
      ST_RDWAIT: begin
        ld      = 1'b1;
        ld_data = mem_rdata;
        nstate  = ST_CMD;
      end
      default: nstate = ST_CMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CMD;
      pend_kind <= CK_NONE;
      pend_rd   <= 1'b0;
      pend_idx  <= '0;
      wp        <= 1'b0;
    end else begin
      state <= nstate;
      if (state == ST_CMD && byte_done) begin
        pend_kind <= dec.kind;
        pend_rd   <= dec.rd;
        pend_idx  <= dec.idx;
      end
      if (state == ST_XADDR && byte_done) begin
        pend_idx <= ext_idx;
      end
      if (state == ST_DATA && byte_done && pend_kind == CK_WPROT) begin
        wp <= rx_byte[BYTE_W-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      secs <= '0;
    end else if (sec_tick) begin
      secs <= secs + 1'b1;
    end
  end

  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> (secs == $past(secs) + 1'b1)); // R4

  AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !wp); // R7

  AST_NO_LOAD_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
    ld |-> !rtc_sdo_oe); // R3

endmodule

// File: tb/rtc_pram_engine_test.sv
module rtc_pram_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 10;

  // {tag, is_read, nbytes, b0, b1, b2, expected}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'd5,  8'd0, 8'd2, 8'h55, 8'hA5, 8'h00, 8'h00},
    {8'd5,  8'd1, 8'd1, 8'hD5, 8'h00, 8'h00, 8'hA5},
    {8'd5,  8'd0, 8'd2, 8'h29, 8'h3C, 8'h00, 8'h00},
    {8'd5,  8'd1, 8'd1, 8'hA9, 8'h00, 8'h00, 8'h3C},
    {8'd6,  8'd0, 8'd3, 8'h3B, 8'h44, 8'h7E, 8'h00},
    {8'd6,  8'd1, 8'd2, 8'hBB, 8'h44, 8'h00, 8'h7E},
    {8'd11, 8'd1, 8'd2, 8'hB8, 8'h14, 8'h00, 8'hA5},
    {8'd11, 8'd1, 8'd2, 8'hB8, 8'h48, 8'h00, 8'h3C},
    {8'd6,  8'd0, 8'd3, 8'hBF & 8'h7F, 8'h7C, 8'h99, 8'h00},
    {8'd6,  8'd1, 8'd2, 8'hBF, 8'h7C, 8'h00, 8'h99}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic rtc_en_n = 1'b1;
  logic rtc_sclk = 1'b1;
  logic rtc_sdi = 1'b0;
  logic rtc_sdo;
  logic rtc_sdo_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_pram_engine uut (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .rtc_en_n  (rtc_en_n),
    .rtc_sclk  (rtc_sclk),
    .rtc_sdi   (rtc_sdi),
    .rtc_sdo   (rtc_sdo),
    .rtc_sdo_oe(rtc_sdo_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      rtc_sclk = 1'b0;
      rtc_sdi  = b[i];
      wait_n(HALF_BIT);
      rtc_sclk = 1'b1;
      wait_n(HALF_BIT);
    end
  endtask

  task automatic recv_byte(output logic [7:0] v, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      rtc_sclk = 1'b0;
      wait_n(HALF_BIT);
      v[i]   = rtc_sdo;
      oe_all = oe_all & rtc_sdo_oe;
      rtc_sclk = 1'b1;
      wait_n(HALF_BIT);
    end
  endtask

  task automatic select;
    rtc_en_n = 1'b0;
    wait_n(HALF_BIT);
  endtask

  task automatic deselect;
    wait_n(HALF_BIT);
    rtc_en_n = 1'b1;
    wait_n(HALF_BIT);
  endtask

  task automatic wr2(input logic [7:0] a, input logic [7:0] b);
    select;
    send_byte(a);
    send_byte(b);
    deselect;
  endtask

  task automatic wr3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    select;
    send_byte(a);
    send_byte(b);
    send_byte(c);
    deselect;
  endtask

  task automatic rd1(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    logic oe;
    select;
    send_byte(a);
    recv_byte(v, oe);
    deselect;
    check(tag, {24'd0, v}, {24'd0, exp});
    check(tag, {31'd0, oe}, 32'd1);
  endtask

  task automatic rd2(input string tag, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] exp);
    logic [7:0] v;
    logic oe;
    select;
    send_byte(a);
    send_byte(b);
    recv_byte(v, oe);
    deselect;
    check(tag, {24'd0, v}, {24'd0, exp});
    check(tag, {31'd0, oe}, 32'd1);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      wait_n(1);
      sec_tick = 1'b0;
      wait_n(1);
    end
  endtask

  initial begin
    string tag;
    logic [7:0] v;
    logic oe;
    wait_n(5);
    rst = 1'b0;
    wait_n(5);

    // R10: reset state
    check("R10 oe after reset", {31'd0, rtc_sdo_oe}, 32'd0);
    rd1("R10 seconds zero after reset", 8'h81, 8'h00);

    // table walk: R5 direct, R6 sectored, R11 aliasing
    for (int k = 0; k < NVEC; k++) begin
      case (VEC[k][55:48])
        8'd5:    tag = "R5 direct access";
        8'd6:    tag = "R6 sector access";
        default: tag = "R11 alias";
      endcase
      select;
      send_byte(VEC[k][31:24]);
      if (VEC[k][39:32] > 1) send_byte(VEC[k][23:16]);
      if (VEC[k][39:32] > 2) send_byte(VEC[k][15:8]);
      if (VEC[k][47:40] == 8'd1) begin
        recv_byte(v, oe);
        check(tag, {24'd0, v}, {24'd0, VEC[k][7:0]});
        check("R3 oe during read", {31'd0, oe}, 32'd1);
      end
      deselect;
      check("R3 oe released", {31'd0, rtc_sdo_oe}, 32'd0);
    end

    // R4: seconds count, byte lanes
    tick(300);
    rd1("R4 seconds byte 0", 8'h81, 8'h2C);
    rd1("R4 seconds byte 1", 8'h85, 8'h01);
    rd1("R4 seconds byte 2", 8'h89, 8'h00);
    rd1("R4 seconds byte 3", 8'h8D, 8'h00);

    // R7: write protect
    wr2(8'h35, 8'h80);
    wr2(8'h55, 8'h00);
    rd1("R7 direct write dropped", 8'hD5, 8'hA5);
    wr3(8'h3B, 8'h44, 8'h00);
    rd2("R7 sector write dropped", 8'hBB, 8'h44, 8'h7E);
    wr2(8'h35, 8'h00);
    wr2(8'h55, 8'h11);
    rd1("R7 write after unprotect", 8'hD5, 8'h11);

    // R9: test and seconds writes consume data, no effect
    wr2(8'h31, 8'hD5);
    check("R9 test data not a command", {31'd0, rtc_sdo_oe}, 32'd0);
    rd1("R9 memory intact after test write", 8'hD5, 8'h11);
    wr2(8'h01, 8'h89);
    check("R9 seconds data not a command", {31'd0, rtc_sdo_oe}, 32'd0);
    rd1("R9 seconds unchanged", 8'h81, 8'h2C);

    // R8: invalid commands
    select;
    send_byte(8'h00);
    send_byte(8'hB1);
    deselect;
    check("R8 invalid no output", {31'd0, rtc_sdo_oe}, 32'd0);
    rd1("R8 next byte is command", 8'hD5, 8'h11);

    // R1: deselected traffic ignored
    send_byte(8'h55);
    send_byte(8'h77);
    send_byte(8'hD5);
    check("R1 no output while deselected", {31'd0, rtc_sdo_oe}, 32'd0);
    rd1("R1 memory and framing intact", 8'hD5, 8'h11);

    // R2: bit order, asymmetric pattern
    wr2(8'h59, 8'h01);
    rd1("R2 msb-first byte", 8'hD9, 8'h01);

    // R10: reset mid-byte discards partial bits
    select;
    for (int i = 0; i < 4; i++) begin
      rtc_sclk = 1'b0;
      rtc_sdi  = 1'b1;
      wait_n(HALF_BIT);
      rtc_sclk = 1'b1;
      wait_n(HALF_BIT);
    end
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(3);
    check("R10 oe low after reset", {31'd0, rtc_sdo_oe}, 32'd0);
    rtc_en_n = 1'b1;
    wait_n(HALF_BIT);
    rd1("R10 framing restarts", 8'hD5, 8'h11);
    rd1("R10 seconds cleared", 8'h81, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule